// File: doc/BRIEF.md
# Two-Channel Bus-Master Block Mover

This block is a bus master that copies blocks of bytes on a shared 8-bit data bus with a 20-bit address. It serves two channels.

Each channel holds a source address, a destination address, a byte count and a control word. Software loads all of them through a single-cycle register write port. The control word gives the transfer direction and the bus-sharing policy.

When a channel is armed, the block raises a bus request and waits for the grant. Each byte then takes two cycles: a read cycle from the source, followed by a write cycle to the destination. Each cycle uses a memory strobe or an I/O strobe. The policy decides when the bus is given back:
- Burst keeps the bus for the whole block.
- Cycle steal gives the bus back after every byte.
- Request mode keeps moving bytes only while that channel's external request line is high.

When a channel's count runs out, it disarms itself and sets a sticky done flag. Software clears the flag by pulsing a write-one-to-clear input.

Top module: `dma2ch`

## Requirements
- R1: After reset, bus_req, all four strobes and both done flags are low.
- R2: No read or write strobe is issued while bus_gnt is low. bus_req stays high while an armed channel waits for the grant.
- R3: Control bits [1:0] select the transfer type: 0 memory to memory, 1 memory to I/O, 2 I/O to memory, 3 I/O to I/O. Bit 1 set means the source is I/O; bit 0 set means the destination is I/O. Each byte is one read cycle from the source, then one write cycle that writes the byte just read to the destination. At most one strobe is high at a time.
- R4: A memory-side address steps by one after each byte, with the carry running through all 20 bits. This includes the carry from bit 15 into bit 16 and the wrap from 0xFFFFF to 0. An I/O-side address stays fixed.
- R5: A count of N moves exactly N bytes. A count of 0 moves 2^CW bytes.
- R6: Burst mode (control bits [3:2] = 00) keeps bus_req high from the first byte to the last.
- R7: Cycle-steal mode (control bits [3:2] = 01) moves one byte per grant. It drops bus_req for at least one clock before asking again.
- R8: Request mode (control bit 3 = 1) starts a byte only while that channel's dreq bit is high. When dreq falls, the block releases the bus after the byte in flight and resumes when dreq rises again.
- R9: When both channels are armed and the grant has not yet arrived, channel 0 is served first.
- R10: On the last byte of its block, a channel sets its done bit and clears its enable, and it moves no further bytes. The done bit stays set until a one is pulsed on the matching done_clr bit.
- R11: While rdy is low during a strobe, the strobe, the address and the write data hold their values.
- R12: Register write port: wr_sel 0 loads the source address, 1 the destination address, 2 the count (low CW bits), 3 the control word. Control bit 4 arms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_sel | input | 2 | Register select |
| wr_data | input | AW | Write data |
| done_clr | input | 2 | Write-one-to-clear for done flags |
| dreq | input | 2 | External request per channel (request mode) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| addr | output | AW | Bus address |
| dout | output | DW | Write data |
| din | input | DW | Read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| rdy | input | 1 | Cycle completes when high |
| done | output | 2 | Sticky done flag per channel |

## Verification
The bench keeps the full 20-bit address and narrows the count to CW = 4. With that setting, a zero count means a block of only 16 bytes, so the 2^CW rule is exercised in a short run. The full address width still lets short blocks cross the 64 KB carry from bit 15 into bit 16, and also the wrap at the top of the 1 MB space. The read data is a function of the address and the bus space, so every logged write can be checked against the source address it must have come from.

// File: rtl/dma2ch.sv
module dma2ch #(
  parameter int AW = 20,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ch,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    done_clr,
  input  logic [1:0]    dreq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] din,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  input  logic          rdy,
  output logic [1:0]    done
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_GAP} st_t;

  st_t st;
  logic cur;
  logic [DW-1:0] hold_q;
  logic [1:0][AW-1:0] src_v, dst_v;
  logic [1:0][CW-1:0] cnt_v;
  logic [1:0][1:0] typ_v, mode_v;
  logic [1:0] en_v, done_v, pend;

  wire step    = (st == S_WR) && rdy;
  wire last    = (cnt_v[cur] == CW'(1));
  wire steal_c = (mode_v[cur] == 2'b01);
  wire reqm_c  = mode_v[cur][1];

  genvar i;
  for (i = 0; i < 2; i++) begin : g_ch
    localparam logic ME = 1'(i);
    logic [AW-1:0] src_r, dst_r;
    logic [CW-1:0] cnt_r;
    logic [1:0] typ_r, mode_r;
    logic en_r, done_r;
    wire mine = step && (cur == ME);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_r <= '0; dst_r <= '0; cnt_r <= '0;
        typ_r <= '0; mode_r <= '0; en_r <= 1'b0; done_r <= 1'b0;
      end else begin
        if (wr_en && wr_ch == ME) begin
          case (wr_sel)
            2'd0: src_r <= wr_data;
            2'd1: dst_r <= wr_data;
            2'd2: cnt_r <= wr_data[CW-1:0];
            default: begin
              typ_r  <= wr_data[1:0];
              mode_r <= wr_data[3:2];
              en_r   <= wr_data[4];
            end
          endcase
        end
        if (mine) begin
          if (!typ_r[1]) src_r <= src_r + 1'b1;
          if (!typ_r[0]) dst_r <= dst_r + 1'b1;
          cnt_r <= cnt_r - 1'b1;
          if (last) en_r <= 1'b0;
        end
        if (mine && last)        done_r <= 1'b1;
        else if (done_clr[i])    done_r <= 1'b0;
      end
    end

    assign src_v[i]  = src_r;
    assign dst_v[i]  = dst_r;
    assign cnt_v[i]  = cnt_r;
    assign typ_v[i]  = typ_r;
    assign mode_v[i] = mode_r;
    assign en_v[i]   = en_r;
    assign done_v[i] = done_r;
    assign pend[i]   = en_r && (!mode_r[1] || dreq[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur    <= 1'b0;
      hold_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (|pend) begin
          cur <= !pend[0];
          st  <= S_REQ;
        end
        S_REQ: begin
          if (!(|pend)) st <= S_IDLE;
          else begin
            cur <= !pend[0];
            if (bus_gnt) st <= S_RD;
          end
        end
        S_RD: if (rdy) begin
          hold_q <= din;
          st     <= S_WR;
        end
        S_WR: if (rdy) begin
          if (last)                     st <= S_IDLE;
          else if (reqm_c && !dreq[cur]) st <= S_IDLE;
          else if (!reqm_c && steal_c)  st <= S_GAP;
          else                          st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req = (st == S_REQ) || (st == S_RD) || (st == S_WR);
  assign addr    = (st == S_WR) ? dst_v[cur] : src_v[cur];
  assign dout    = hold_q;
  assign mem_rd  = (st == S_RD) && !typ_v[cur][1];
  assign io_rd   = (st == S_RD) &&  typ_v[cur][1];
  assign mem_wr  = (st == S_WR) && !typ_v[cur][0];
  assign io_wr   = (st == S_WR) &&  typ_v[cur][0];
  assign done    = done_v;

  wire any_stb = mem_rd | mem_wr | io_rd | io_wr;

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  p_strobe_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> (bus_req && bus_gnt));

  p_hold_on_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && !rdy && !wr_en) |=>
      ($stable(addr) && $stable(dout) && $stable({mem_rd, mem_wr, io_rd, io_wr})));

  p_steal_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reqm_c && steal_c) |=> !bus_req);

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(done & ~done_clr)) |=> ((done & $past(done & ~done_clr)) == $past(done & ~done_clr)));

  p_disarm_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> !en_v[0]);

endmodule

// File: tb/dma2ch_bench.sv
module dma2ch_bench;
  localparam int AW = 20;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_ch = 0;
  logic [1:0] wr_sel = 0;
  logic [AW-1:0] wr_data = 0;
  logic [1:0] done_clr = 0, dreq = 0;
  logic bus_req, bus_gnt, gnt_en = 1;
  logic [AW-1:0] addr;
  logic [7:0] dout, din;
  logic mem_rd, mem_wr, io_rd, io_wr, rdy = 1;
  logic [1:0] done;

  int checks = 0, fails = 0, rises = 0;
  logic req_prev = 0;
  logic [19:0] la[$];
  logic [7:0]  ld[$];
  logic        lio[$];

  always #5 clk = ~clk;

  assign bus_gnt = bus_req && gnt_en;
  assign din = io_rd ? ~addr[7:0] : (addr[7:0] ^ addr[19:12]);

  dma2ch #(.AW(AW), .CW(CW), .DW(8)) u_dma2ch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .done_clr(done_clr), .dreq(dreq), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .addr(addr), .dout(dout), .din(din), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .rdy(rdy), .done(done));

  always @(posedge clk) begin
    if ((mem_wr || io_wr) && rdy) begin
      la.push_back(addr); ld.push_back(dout); lio.push_back(io_wr);
    end
    if (bus_req && !req_prev) rises <= rises + 1;
    req_prev <= bus_req;
  end

  function automatic logic [7:0] rdfn(logic io, logic [19:0] a);
    return io ? ~a[7:0] : (a[7:0] ^ a[19:12]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic ch, logic [1:0] sel, logic [19:0] d);
    @(negedge clk);
    wr_en = 1; wr_ch = ch; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic prog(logic ch, logic [19:0] s, logic [19:0] d, int cnt,
                      logic [1:0] ty, logic [1:0] md);
    wreg(ch, 2'd0, s);
    wreg(ch, 2'd1, d);
    wreg(ch, 2'd2, 20'(cnt));
    wreg(ch, 2'd3, {15'd0, 1'b1, md, ty});
  endtask

  task automatic wait_done(logic ch, string tag);
    int t = 0;
    while (!done[ch] && t < 3000) begin @(negedge clk); t++; end
    chk({tag, " done flag set"}, done[ch], 1);
  endtask

  task automatic clr_done(logic [1:0] m);
    @(negedge clk); done_clr = m;
    @(negedge clk); done_clr = 0;
  endtask

  task automatic reset_log();
    la.delete(); ld.delete(); lio.delete(); rises = 0;
  endtask

  task automatic verify(string tag, int base, int n, logic [19:0] s,
                        logic [19:0] d, logic [1:0] ty);
    chk({tag, " write count"}, la.size() >= base + n, 1);
    if (la.size() < base + n) return;
    for (int k = 0; k < n; k++) begin
      logic [19:0] es, ed;
      es = ty[1] ? s : s + 20'(k);
      ed = ty[0] ? d : d + 20'(k);
      chk({tag, " addr"}, la[base+k], ed);
      chk({tag, " data"}, ld[base+k], rdfn(ty[1], es));
      chk({tag, " space"}, lio[base+k], ty[0]);
    end
  endtask

  task automatic t_reset();
    chk("R1 bus_req", bus_req, 0);
    chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_grant();
    reset_log();
    gnt_en = 0;
    prog(0, 20'h01000, 20'h02000, 3, 2'd0, 2'd0);
    repeat (6) @(negedge clk);
    chk("R2 bus_req while waiting", bus_req, 1);
    chk("R2 no strobe without grant", {mem_rd, mem_wr, io_rd, io_wr}, 0);
    chk("R2 no writes without grant", la.size(), 0);
    gnt_en = 1;
    wait_done(0, "R12");
    verify("R3 R12 mem-mem", 0, 3, 20'h01000, 20'h02000, 2'd0);
    clr_done(2'b01);
  endtask

  task automatic t_carry();
    reset_log();
    prog(0, 20'h0FFFE, 20'h1FFFF, 4, 2'd0, 2'd0);
    wait_done(0, "R4");
    verify("R4 carry bit15", 0, 4, 20'h0FFFE, 20'h1FFFF, 2'd0);
    clr_done(2'b01);
    reset_log();
    prog(1, 20'hFFFFF, 20'hFFFFE, 3, 2'd0, 2'd0);
    wait_done(1, "R4");
    verify("R4 wrap 1MB", 0, 3, 20'hFFFFF, 20'hFFFFE, 2'd0);
    clr_done(2'b10);
  endtask

  task automatic t_types();
    for (int ty = 1; ty < 4; ty++) begin
      reset_log();
      prog(0, 20'h30010, 20'h40020, 3, 2'(ty), 2'd0);
      wait_done(0, "R3");
      verify("R3 R4 type", 0, 3, 20'h30010, 20'h40020, 2'(ty));
      clr_done(2'b01);
    end
  endtask

  task automatic t_zero();
    reset_log();
    prog(0, 20'h50000, 20'h60000, 0, 2'd0, 2'd0);
    wait_done(0, "R5");
    repeat (4) @(negedge clk);
    chk("R5 zero count bytes", la.size(), 16);
    verify("R5 zero count", 0, 16, 20'h50000, 20'h60000, 2'd0);
    clr_done(2'b01);
    reset_log();
    prog(0, 20'h50100, 20'h60100, 5, 2'd0, 2'd0);
    wait_done(0, "R5");
    repeat (4) @(negedge clk);
    chk("R5 count 5 bytes", la.size(), 5);
    chk("R6 burst single request", rises, 1);
    clr_done(2'b01);
  endtask

  task automatic t_steal();
    reset_log();
    prog(1, 20'h70000, 20'h71000, 4, 2'd0, 2'd1);
    wait_done(1, "R7");
    repeat (4) @(negedge clk);
    chk("R7 one request per byte", rises, 4);
    verify("R7 steal", 0, 4, 20'h70000, 20'h71000, 2'd0);
    clr_done(2'b10);
  endtask

  task automatic t_request();
    int n1, t;
    reset_log();
    dreq = 0;
    prog(0, 20'h80000, 20'h81000, 10, 2'd0, 2'd2);
    repeat (8) @(negedge clk);
    chk("R8 idle without dreq", bus_req, 0);
    chk("R8 no bytes without dreq", la.size(), 0);
    dreq = 2'b01;
    t = 0;
    while (la.size() < 3 && t < 200) begin @(negedge clk); t++; end
    dreq = 0;
    repeat (8) @(negedge clk);
    n1 = la.size();
    chk("R8 paused below count", (n1 >= 3) && (n1 < 10), 1);
    chk("R8 bus released", bus_req, 0);
    chk("R8 not done", done[0], 0);
    repeat (10) @(negedge clk);
    chk("R8 no progress while low", la.size(), n1);
    dreq = 2'b01;
    wait_done(0, "R8");
    dreq = 0;
    verify("R8 resumed", 0, 10, 20'h80000, 20'h81000, 2'd0);
    clr_done(2'b01);
  endtask

  task automatic t_priority();
    reset_log();
    gnt_en = 0;
    prog(1, 20'h90000, 20'hA1000, 3, 2'd0, 2'd0);
    prog(0, 20'h92000, 20'hA0000, 3, 2'd0, 2'd0);
    repeat (2) @(negedge clk);
    gnt_en = 1;
    wait_done(0, "R9");
    wait_done(1, "R9");
    verify("R9 ch0 first", 0, 3, 20'h92000, 20'hA0000, 2'd0);
    verify("R9 ch1 second", 3, 3, 20'h90000, 20'hA1000, 2'd0);
    clr_done(2'b11);
  endtask

  task automatic t_done();
    int n;
    reset_log();
    prog(1, 20'hB0000, 20'hB1000, 2, 2'd0, 2'd0);
    wait_done(1, "R10");
    n = la.size();
    repeat (20) @(negedge clk);
    chk("R10 sticky", done[1], 1);
    chk("R10 disarmed no more bytes", la.size(), n);
    chk("R10 bus idle after done", bus_req, 0);
    clr_done(2'b01);
    chk("R10 other clear ignored", done[1], 1);
    clr_done(2'b10);
    chk("R10 cleared by write-one", done[1], 0);
  endtask

  task automatic t_wait();
    int t = 0;
    logic [19:0] a0;
    reset_log();
    rdy = 0;
    prog(0, 20'hC0005, 20'hC1000, 1, 2'd0, 2'd0);
    while (!mem_rd && t < 100) begin @(negedge clk); t++; end
    a0 = addr;
    chk("R11 read address", a0, 20'hC0005);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 strobe held", mem_rd, 1);
      chk("R11 addr held", addr, a0);
    end
    rdy = 1;
    @(negedge clk);
    rdy = 0;
    @(negedge clk);
    chk("R11 write strobe held", mem_wr, 1);
    chk("R11 write data held", dout, rdfn(0, 20'hC0005));
    rdy = 1;
    wait_done(0, "R11");
    verify("R11 wait", 0, 1, 20'hC0005, 20'hC1000, 2'd0);
    clr_done(2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_grant();
    t_carry();
    t_types();
    t_zero();
    t_steal();
    t_request();
    t_priority();
    t_done();
    t_wait();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule